// File: doc/BRIEF.md
# Indexed Configuration Byte Port

This block gives a host a two-byte I/O window into a 256-entry, byte-wide configuration space. The even byte of the window is an index register, and the odd byte is the data register for the entry that the index selects. Software writes an index and then reads or writes the data byte. The space holds the settings for the peripheral functions around it, such as the serial port base addresses. Those functions see each setting through their own taps into the array.

Some entries hold settings that the rest of the chip cannot follow. A write filter protects them. The first serial base entry (0xE7) accepts only 0xFE, and the second serial base entry (0xE8) accepts only 0xBE. A data write with any other value is discarded.

The window answers only while an enable bit from a neighbouring bridge register is set. The block samples that bit into a flop, and the flop clears on reset. Reset also loads a fixed set of default values into the array.

Top module: `cfgport_window`

## Requirements
- R1: After reset the index is 0x00, and entries 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 hold 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE. Every other entry holds 0x00. `io_rdata` is 0xFF, and `io_rvalid` and `io_claim` are low.
- R2: The window is enabled in a cycle only if `bridge_en` was high at the previous rising clock edge. In that cycle `io_claim` is high during any read or write to the window.
- R3: A claimed write to `BASE_ADDR` (0x3F0) stores `io_wdata` as the index. The index changes on no other event.
- R4: A read with `io_rd` high in cycle t raises `io_rvalid` in cycle t+1. If the read is claimed, `io_rdata` in cycle t+1 holds the entry at the current index, at either offset of the window.
- R5: A claimed write to `BASE_ADDR`+1 stores `io_wdata` into the entry at the current index, for every index except the two filtered ones.
- R6: A data write to index 0xE7 with a value other than 0xFE is dropped. A data write to index 0xE8 with a value other than 0xBE is dropped. In both cases the entry keeps its old value.
- R7: The window claims only accesses with `io_bytes` equal to 1. A wider access changes no state, and a wider read returns 0xFF.
- R8: Accesses to addresses outside `BASE_ADDR` and `BASE_ADDR`+1 are not claimed and change no state.
- R9: While the window is disabled, reads return 0xFF, writes change no entry, and the latched index is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_bytes | input | SIZE_W | Access size in bytes |
| io_wdata | input | 8 | Write data byte |
| bridge_en | input | 1 | Window enable bit from the bridge register |
| io_rdata | output | 8 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read response, one cycle after io_rd |
| io_claim | output | 1 | The window accepts the current access |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a window at 0x3F0 and a 3-bit size field. The index is fixed at eight bits, so the whole 256-entry space is small enough to sweep completely. The bench reads the reset default of every entry, writes an arithmetic pattern to every index, and reads each entry back. This covers the two filtered entries inside the same sweep. Directed steps then cover the following:
- wide accesses;
- neighbouring addresses;
- an enable bit that is still low;
- index retention across a disabled period.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int CFG_IDX_W = 8;
  localparam int CFG_DEPTH = 1 << CFG_IDX_W;

  typedef logic [7:0]           cfg_byte_t;
  typedef logic [CFG_IDX_W-1:0] cfg_idx_t;

  // decoded events for one access cycle
  typedef struct packed {
    logic claim;
    logic rd;
    logic idx_we;
    logic dat_we;
  } cfg_dec_t;

  localparam cfg_idx_t  SER_A_IDX = 8'hE7;
  localparam cfg_byte_t SER_A_FIX = 8'hFE;
  localparam cfg_idx_t  SER_B_IDX = 8'hE8;
  localparam cfg_byte_t SER_B_FIX = 8'hBE;

  // power-on contents of one entry
  function automatic cfg_byte_t cfg_reset_value(input cfg_idx_t idx);
    case (idx)
      8'hE0:    return 8'h3C;
      8'hE2:    return 8'h03;
      8'hE3:    return 8'hFC;
      8'hE6:    return 8'hDE;
      SER_A_IDX: return SER_A_FIX;
      SER_B_IDX: return SER_B_FIX;
      default:  return 8'h00;
    endcase
  endfunction

  // write filter: pinned entries take only their single legal value
  function automatic logic cfg_write_ok(input cfg_idx_t idx, input cfg_byte_t val);
    case (idx)
      SER_A_IDX: return val == SER_A_FIX;
      SER_B_IDX: return val == SER_B_FIX;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 3,
  parameter int BASE_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [SIZE_W-1:0] io_bytes,
  input  logic              bridge_en,
  output logic              en_q,
  output cfg_dec_t          dec
);

  localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] DAT_PORT = IDX_PORT + ADDR_W'(1);

  logic byte_ok, at_idx, at_dat, any_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= bridge_en;
  end

  assign byte_ok = (io_bytes == SIZE_W'(1));
  assign at_idx  = (io_addr == IDX_PORT);
  assign at_dat  = (io_addr == DAT_PORT);
  assign any_acc = io_wr | io_rd;

  assign dec.claim  = en_q & byte_ok & (at_idx | at_dat) & any_acc;
  assign dec.rd     = io_rd;
  assign dec.idx_we = dec.claim & io_wr & at_idx;
  assign dec.dat_we = dec.claim & io_wr & at_dat;

  // R8
  window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != IDX_PORT && io_addr != DAT_PORT) |-> !(dec.idx_we || dec.dat_we));

endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
  import cfgport_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idx_we,
  input  logic      dat_we,
  input  cfg_byte_t wbyte,
  output cfg_idx_t  idx_q,
  output cfg_byte_t rd_byte,
  output logic      commit
);

  cfg_byte_t              mem [CFG_DEPTH];
  logic [CFG_DEPTH-1:0]   we_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= wbyte;
  end

  assign commit = dat_we & cfg_write_ok(idx_q, wbyte);

  for (genvar g = 0; g < CFG_DEPTH; g++) begin : g_sel
    assign we_vec[g] = commit & (idx_q == cfg_idx_t'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_DEPTH; i++) mem[i] <= cfg_reset_value(cfg_idx_t'(i));
    end else begin
      for (int i = 0; i < CFG_DEPTH; i++) if (we_vec[i]) mem[i] <= wbyte;
    end
  end

  assign rd_byte = mem[idx_q];

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(idx_q));

  // R5
  commit_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> rd_byte == $past(wbyte));

  // R6
  ser_a_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx_q == SER_A_IDX && wbyte != SER_A_FIX) |=> $stable(mem[SER_A_IDX]));

  // R6
  ser_b_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && idx_q == SER_B_IDX && wbyte != SER_B_FIX) |=> $stable(mem[SER_B_IDX]));

endmodule

// File: rtl/cfgport_readout.sv
module cfgport_readout
  import cfgport_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd,
  input  logic      claim,
  input  cfg_byte_t rd_byte,
  output cfg_byte_t rdata,
  output logic      rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= 8'hFF;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= claim ? rd_byte : 8'hFF;
    end
  end

  // R4
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);

  // R9
  miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !claim) |=> rdata == 8'hFF);

endmodule

// File: rtl/cfgport_window.sv
module cfgport_window
  import cfgport_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 3,
  parameter int BASE_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [SIZE_W-1:0] io_bytes,
  input  logic [7:0]        io_wdata,
  input  logic              bridge_en,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              io_claim
);

  cfg_dec_t  dec;
  logic      en_q;
  logic      commit;
  cfg_idx_t  idx_q;
  cfg_byte_t rd_byte;

  cfgport_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_bytes(io_bytes), .bridge_en(bridge_en), .en_q(en_q), .dec(dec)
  );

  cfgport_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .idx_we(dec.idx_we), .dat_we(dec.dat_we),
    .wbyte(io_wdata), .idx_q(idx_q), .rd_byte(rd_byte), .commit(commit)
  );

  cfgport_readout u_rd (
    .clk(clk), .rst_n(rst_n), .rd(dec.rd), .claim(dec.claim),
    .rd_byte(rd_byte), .rdata(io_rdata), .rvalid(io_rvalid)
  );

  assign io_claim = dec.claim;

  // R2
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !commit);

  // R9
  idx_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(idx_q));

  // R7
  size_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_bytes != SIZE_W'(1)) |-> !commit);

endmodule

// File: tb/tb_cfgport_window.sv
module tb_cfgport_window;

  localparam logic [15:0] BASE = 16'h03F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [2:0]  io_bytes = 3'd1;
  logic [7:0]  io_wdata = '0;
  logic        bridge_en = 1'b0;
  logic [7:0]  io_rdata;
  logic        io_rvalid, io_claim;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] model [256];
  logic [7:0] model_idx;
  logic [7:0] got;

  always #2 clk = ~clk;   // 250 MHz

  cfgport_window dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_bytes(io_bytes), .io_wdata(io_wdata), .bridge_en(bridge_en),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid), .io_claim(io_claim)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [2:0] n);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_bytes = n; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_bytes = 3'd1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [2:0] n, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_bytes = n; io_rd = 1'b1;
    @(negedge clk);
    d = io_rdata;
    if (io_rvalid !== 1'b1) begin
      checks++; fails++;
      $display("FAIL R4: rvalid actual %b expected 1", io_rvalid);
    end
    io_rd = 1'b0; io_bytes = 3'd1;
  endtask

  function automatic logic [7:0] pattern(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    model[8'hE0] = 8'h3C; model[8'hE2] = 8'h03; model[8'hE3] = 8'hFC;
    model[8'hE6] = 8'hDE; model[8'hE7] = 8'hFE; model[8'hE8] = 8'hBE;
    model_idx = 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rdata", io_rdata, 8'hFF);
    check("R1 reset rvalid", {7'd0, io_rvalid}, 8'h00);
    check("R1 reset claim", {7'd0, io_claim}, 8'h00);

    // R9: disabled after reset
    rd(BASE + 16'd1, 3'd1, got);
    check("R9 read while disabled", got, 8'hFF);

    // R2: enable takes one edge; claim visible in the access cycle
    @(negedge clk); bridge_en = 1'b1;
    @(negedge clk);
    io_addr = BASE + 16'd1; io_rd = 1'b1; io_bytes = 3'd1;
    #1 check("R2 claim when enabled", {7'd0, io_claim}, 8'h01);
    @(negedge clk);
    check("R1 index zero after reset", io_rdata, model[0]);
    io_rd = 1'b0;

    // R1 sweep of defaults
    for (int i = 0; i < 256; i++) begin
      wr(BASE, 8'(i), 3'd1);
      rd(BASE + 16'd1, 3'd1, got);
      check($sformatf("R1 default idx %02h", i), got, model[i]);
    end
    model_idx = 8'hFF;

    // R5/R6 write sweep
    for (int i = 0; i < 256; i++) begin
      wr(BASE, 8'(i), 3'd1);
      wr(BASE + 16'd1, pattern(i), 3'd1);
      if (!((i == 8'hE7 && pattern(i) != 8'hFE) || (i == 8'hE8 && pattern(i) != 8'hBE)))
        model[i] = pattern(i);
    end
    for (int i = 0; i < 256; i++) begin
      wr(BASE, 8'(i), 3'd1);
      rd(BASE + 16'd1, 3'd1, got);
      check((i == 8'hE7 || i == 8'hE8) ? $sformatf("R6 filtered idx %02h", i)
                                       : $sformatf("R5 readback idx %02h", i), got, model[i]);
    end

    // R6 legal values accepted, illegal dropped
    wr(BASE, 8'hE8, 3'd1); wr(BASE + 16'd1, 8'hBF, 3'd1);
    rd(BASE + 16'd1, 3'd1, got); check("R6 E8 reject BF", got, 8'hBE);
    wr(BASE, 8'hE7, 3'd1); wr(BASE + 16'd1, 8'h00, 3'd1);
    rd(BASE + 16'd1, 3'd1, got); check("R6 E7 reject 00", got, 8'hFE);
    wr(BASE + 16'd1, 8'hFE, 3'd1);
    rd(BASE + 16'd1, 3'd1, got); check("R6 E7 accept FE", got, 8'hFE);

    // R3 / R4: index write, read at offset 0
    wr(BASE, 8'h55, 3'd1);
    rd(BASE, 3'd1, got); check("R4 read at index offset", got, model[8'h55]);
    check("R3 index written", got, pattern(8'h55));

    // R7 wide accesses
    wr(BASE + 16'd1, 8'h00, 3'd2);
    wr(BASE, 8'h10, 3'd4);
    rd(BASE + 16'd1, 3'd2, got); check("R7 wide read", got, 8'hFF);
    rd(BASE + 16'd1, 3'd1, got); check("R7 wide write ignored", got, model[8'h55]);

    // R8 neighbouring addresses
    wr(BASE + 16'd2, 8'h10, 3'd1);
    wr(BASE - 16'd1, 8'h10, 3'd1);
    wr(BASE + 16'd3, 8'h00, 3'd1);
    rd(BASE + 16'd2, 3'd1, got); check("R8 outside read", got, 8'hFF);
    rd(BASE + 16'd1, 3'd1, got); check("R8 outside writes ignored", got, model[8'h55]);

    // R9 disabled: writes dropped, index kept
    @(negedge clk); bridge_en = 1'b0;
    wr(BASE, 8'h20, 3'd1);
    wr(BASE + 16'd1, 8'h77, 3'd1);
    rd(BASE + 16'd1, 3'd1, got); check("R9 disabled read", got, 8'hFF);
    @(negedge clk); bridge_en = 1'b1;
    rd(BASE + 16'd1, 3'd1, got); check("R9 index kept", got, model[8'h55]);
    wr(BASE, 8'h20, 3'd1);
    rd(BASE + 16'd1, 3'd1, got); check("R9 entry unchanged", got, model[8'h20]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule